// File: doc/BRIEF.md
# Run-Length Image Decoder with Flip, Clip and Key-Colour Masking

The block turns an 8-bit-per-pixel run-length-coded image, arriving one byte at a time, into a stream of destination pixel writes. Each write carries a destination x, a destination y and a colour. A one-cycle `start` pulse arms a new image. The first four bytes hold the image width and the image height. Tokens follow them, and each token is one of two kinds: a solid span, which repeats one colour, or a literal run, which carries its own colour bytes.

Pixels are produced in row-major order of the source image. The x position wraps to the next row at the image width, so a token may run across a row boundary. While decoding, the block can mirror the image horizontally, vertically, or both. It then adds a destination offset and discards any pixel that lands outside the clip rectangle. It can also drop pixels of the key colour, which is a parameter with default 0. Discarded pixels still use up their place in the stream.

When every pixel of the image has been produced, `done` rises. Any bytes that arrive after that are drained and dropped.

Top module: `rle_blit_decoder`

## Requirements
- R1: After reset, and until a `start` pulse, `px_valid`, `done` and `in_ready` are all 0. A `start` pulse begins a new image and clears `done` on the next cycle.
- R2: The first four accepted bytes are, in order: width low byte, width high byte, height low byte, height high byte. Both words are little-endian.
- R3: A token byte with bit 7 = 0 is a span. Bits 6:0 give the length L, where 0 means 128. The next byte is the colour, and the token yields L pixels of that colour.
- R4: A token byte with bit 7 = 1 is a literal run. Bits 6:0 give the length L, where 0 means 128. The next L bytes are colours, which are output in the order they arrive.
- R5: Pixels are produced in row-major source order. Column c runs from 0 to width−1 and then wraps to column 0 of the next row, including in the middle of a token.
- R6: With `flip_h` = 1, source column c is placed at column width−1−c. With `flip_v` = 1, source row r is placed at row height−1−r.
- R7: The output coordinate is (`x_off` + mapped column, `y_off` + mapped row). A pixel is written only if that x < `clip_w` and that y < `clip_h`. Other pixels are consumed and produce no write.
- R8: With `mask_en` = 1, pixels whose colour equals the key colour (default 0) are not written. With `mask_en` = 0, they are written like any other colour.
- R9: After width×height pixels, `done` = 1 and stays 1 until the next `start`. Later bytes are accepted and dropped, with no write. A zero width or zero height gives `done` right after the header.
- R10: While `px_valid` = 1 and `px_ready` = 0, `px_valid`, `px_x`, `px_y` and `px_color` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle pulse that begins a new image |
| flip_h | input | 1 | Mirror columns |
| flip_v | input | 1 | Mirror rows |
| mask_en | input | 1 | Drop pixels of the key colour |
| x_off | input | COORD_W | Destination x offset |
| y_off | input | COORD_W | Destination y offset |
| clip_w | input | COORD_W | Clip rectangle width |
| clip_h | input | COORD_W | Clip rectangle height |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted |
| in_byte | input | 8 | Coded stream byte |
| px_valid | output | 1 | Pixel write valid |
| px_ready | input | 1 | Pixel write accepted |
| px_x | output | COORD_W | Destination x |
| px_y | output | COORD_W | Destination y |
| px_color | output | 8 | Pixel colour |
| done | output | 1 | Image complete |

## Verification
The assertions assume three things about the inputs. First, the flip, mask, offset and clip inputs stay constant from a `start` pulse until `done`. Second, `start` is never raised while a pixel is held waiting on `px_ready`, except as a deliberate abort. Third, the header describes the token stream that follows it. The bench sets all configuration inputs before each `start` pulse and leaves them unchanged until the image is finished. It also builds every token stream from the same width and height it writes into the header, so the token lengths always add up to exactly width×height pixels.

// File: rtl/rle_pkg.sv
package rle_pkg;
   localparam int LEN_W = 7;
   localparam int RUN_W = LEN_W + 1;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_HDR,
      ST_TOKEN,
      ST_SPANCOL,
      ST_LITCOL,
      ST_EMIT,
      ST_DONE
   } rle_state_e;

   // length field of a token byte, zero standing for the largest run
   function automatic logic [RUN_W-1:0] run_len(input logic [7:0] tok);
      if (tok[LEN_W-1:0] == '0) run_len = RUN_W'(1 << LEN_W);
      else                      run_len = {1'b0, tok[LEN_W-1:0]};
   endfunction
endpackage

// File: rtl/rle_raster_cnt.sv
module rle_raster_cnt #(
   parameter int COORD_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr,
   input  logic               step,
   input  logic [COORD_W-1:0] width,
   input  logic [COORD_W-1:0] height,
   output logic [COORD_W-1:0] col,
   output logic [COORD_W-1:0] row,
   output logic               last
);
   logic row_end;
   assign row_end = (col == width - COORD_W'(1));
   assign last    = row_end && (row == height - COORD_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         col <= '0;
         row <= '0;
      end else if (clr) begin
         col <= '0;
         row <= '0;
      end else if (step) begin
         if (row_end) begin
            col <= '0;
            row <= row + COORD_W'(1);
         end else begin
            col <= col + COORD_W'(1);
         end
      end
   end
endmodule

// File: rtl/rle_coord_map.sv
module rle_coord_map #(
   parameter int COORD_W = 16,
   parameter bit FLIP_EN = 1'b1
) (
   input  logic [COORD_W-1:0] col,
   input  logic [COORD_W-1:0] row,
   input  logic [COORD_W-1:0] width,
   input  logic [COORD_W-1:0] height,
   input  logic               flip_h,
   input  logic               flip_v,
   input  logic [COORD_W-1:0] x_off,
   input  logic [COORD_W-1:0] y_off,
   input  logic [COORD_W-1:0] clip_w,
   input  logic [COORD_W-1:0] clip_h,
   output logic [COORD_W-1:0] dst_x,
   output logic [COORD_W-1:0] dst_y,
   output logic               in_clip
);
   logic [COORD_W-1:0] mx, my;
   logic [COORD_W:0]   sx, sy;

   generate
      if (FLIP_EN) begin : g_flip
         assign mx = flip_h ? (width  - COORD_W'(1) - col) : col;
         assign my = flip_v ? (height - COORD_W'(1) - row) : row;
      end else begin : g_noflip
         logic unused_flip;
         assign unused_flip = flip_h ^ flip_v ^ (^width) ^ (^height);
         assign mx = col;
         assign my = row;
      end
   endgenerate

   // one extra bit so an offset pushing past the top is clipped, not wrapped
   assign sx      = {1'b0, x_off} + {1'b0, mx};
   assign sy      = {1'b0, y_off} + {1'b0, my};
   assign in_clip = (sx < {1'b0, clip_w}) && (sy < {1'b0, clip_h});
   assign dst_x   = sx[COORD_W-1:0];
   assign dst_y   = sy[COORD_W-1:0];
endmodule

// File: rtl/rle_blit_decoder.sv
module rle_blit_decoder
   import rle_pkg::*;
#(
   parameter int          COORD_W      = 16,
   parameter logic [7:0]  TRANSP_COLOR = 8'h00,
   parameter bit          FLIP_EN      = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic               flip_h,
   input  logic               flip_v,
   input  logic               mask_en,
   input  logic [COORD_W-1:0] x_off,
   input  logic [COORD_W-1:0] y_off,
   input  logic [COORD_W-1:0] clip_w,
   input  logic [COORD_W-1:0] clip_h,
   input  logic               in_valid,
   output logic               in_ready,
   input  logic [7:0]         in_byte,
   output logic               px_valid,
   input  logic               px_ready,
   output logic [COORD_W-1:0] px_x,
   output logic [COORD_W-1:0] px_y,
   output logic [7:0]         px_color,
   output logic               done
);
   localparam int HDR_W = 16;

   generate
      if (COORD_W < HDR_W) begin : g_bad_coord_w
         $error("rle_blit_decoder: COORD_W must hold a 16-bit header word");
      end
   endgenerate

   rle_state_e          st;
   logic [1:0]          hdr_idx;
   logic [7:0]          w_lo, h_lo;
   logic [COORD_W-1:0]  img_w, img_h;
   logic [RUN_W-1:0]    run_left;
   logic                run_lit;
   logic [7:0]          pix_col;

   logic [COORD_W-1:0]  col, row;
   logic                last_px, in_clip, vis, accept, step;

   assign in_ready = (st == ST_HDR) || (st == ST_TOKEN) || (st == ST_SPANCOL) ||
                     (st == ST_LITCOL) || (st == ST_DONE);
   assign accept   = in_valid && in_ready;
   assign vis      = in_clip && !(mask_en && (pix_col == TRANSP_COLOR));
   assign px_valid = (st == ST_EMIT) && vis;
   assign step     = (st == ST_EMIT) && (!vis || px_ready);
   assign px_color = pix_col;
   assign done     = (st == ST_DONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         hdr_idx  <= '0;
         w_lo     <= '0;
         h_lo     <= '0;
         img_w    <= '0;
         img_h    <= '0;
         run_left <= '0;
         run_lit  <= 1'b0;
         pix_col  <= '0;
      end else if (start) begin
         st      <= ST_HDR;
         hdr_idx <= '0;
      end else begin
         case (st)
            ST_HDR: if (accept) begin
               hdr_idx <= hdr_idx + 2'd1;
               case (hdr_idx)
                  2'd0: w_lo  <= in_byte;
                  2'd1: img_w <= COORD_W'({in_byte, w_lo});
                  2'd2: h_lo  <= in_byte;
                  default: begin
                     img_h <= COORD_W'({in_byte, h_lo});
                     st    <= ((img_w == '0) || ({in_byte, h_lo} == 16'd0)) ? ST_DONE : ST_TOKEN;
                  end
               endcase
            end
            ST_TOKEN: if (accept) begin
               run_left <= run_len(in_byte);
               run_lit  <= in_byte[7];
               st       <= in_byte[7] ? ST_LITCOL : ST_SPANCOL;
            end
            ST_SPANCOL, ST_LITCOL: if (accept) begin
               pix_col <= in_byte;
               st      <= ST_EMIT;
            end
            ST_EMIT: if (step) begin
               run_left <= run_left - RUN_W'(1);
               if (last_px)                    st <= ST_DONE;
               else if (run_left == RUN_W'(1)) st <= ST_TOKEN;
               else if (run_lit)               st <= ST_LITCOL;
            end
            default: ;
         endcase
      end
   end

   rle_raster_cnt #(.COORD_W(COORD_W)) u_raster (
      .clk(clk), .rst_n(rst_n), .clr(start), .step(step),
      .width(img_w), .height(img_h),
      .col(col), .row(row), .last(last_px)
   );

   rle_coord_map #(.COORD_W(COORD_W), .FLIP_EN(FLIP_EN)) u_map (
      .col(col), .row(row), .width(img_w), .height(img_h),
      .flip_h(flip_h), .flip_v(flip_v),
      .x_off(x_off), .y_off(y_off), .clip_w(clip_w), .clip_h(clip_h),
      .dst_x(px_x), .dst_y(px_y), .in_clip(in_clip)
   );
endmodule

// File: rtl/rle_decoder_chk.sv
module rle_decoder_chk #(
   parameter int         COORD_W      = 16,
   parameter logic [7:0] TRANSP_COLOR = 8'h00
) (
   input logic               clk,
   input logic               rst_n,
   input logic               start,
   input logic               mask_en,
   input logic [COORD_W-1:0] clip_w,
   input logic [COORD_W-1:0] clip_h,
   input logic               px_valid,
   input logic               px_ready,
   input logic [COORD_W-1:0] px_x,
   input logic [COORD_W-1:0] px_y,
   input logic [7:0]         px_color,
   input logic               done
);
   assert_start_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> !done);

   assert_clip_R7: assert property (@(posedge clk) disable iff (!rst_n)
      px_valid |-> ((px_x < clip_w) && (px_y < clip_h)));

   assert_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (px_valid && mask_en) |-> (px_color != TRANSP_COLOR));

   assert_done_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !px_valid);

   assert_done_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> done);

   assert_px_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (px_valid && !px_ready && !start) |=>
         (px_valid && $stable(px_x) && $stable(px_y) && $stable(px_color)));
endmodule

bind rle_blit_decoder rle_decoder_chk #(.COORD_W(COORD_W), .TRANSP_COLOR(TRANSP_COLOR)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .mask_en(mask_en),
   .clip_w(clip_w), .clip_h(clip_h),
   .px_valid(px_valid), .px_ready(px_ready),
   .px_x(px_x), .px_y(px_y), .px_color(px_color), .done(done)
);

// File: tb/tb_rle_blit_decoder.sv
`timescale 1ns/1ps
module tb_rle_blit_decoder;
   localparam int CW = 16;
   localparam int NC = 8;
   // case table: image size, flips, mask, offsets, clip, single 128-span stream
   localparam int T_W  [NC] = '{5, 5, 4, 6, 7, 256, 16, 0};
   localparam int T_H  [NC] = '{3, 3, 4, 2, 3, 1,   8,  3};
   localparam int T_FH [NC] = '{0, 1, 1, 0, 0, 0,   0,  0};
   localparam int T_FV [NC] = '{0, 0, 1, 0, 0, 0,   1,  0};
   localparam int T_MK [NC] = '{0, 0, 0, 1, 0, 0,   0,  0};
   localparam int T_XO [NC] = '{0, 0, 2, 0, 3, 0,   1,  0};
   localparam int T_YO [NC] = '{0, 0, 0, 0, 1, 0,   0,  0};
   localparam int T_CW [NC] = '{64,64,64,64, 8, 300, 64, 64};
   localparam int T_CH [NC] = '{64,64,64,64, 3, 4,   64, 64};
   localparam int T_BG [NC] = '{0, 0, 0, 0, 0, 0,   1,  0};

   logic clk = 0, rst_n = 0, start = 0;
   logic flip_h = 0, flip_v = 0, mask_en = 0;
   logic [CW-1:0] x_off = 0, y_off = 0, clip_w = 0, clip_h = 0;
   logic in_valid = 0, in_ready, px_valid, px_ready = 0, done;
   logic [7:0] in_byte = 0, px_color;
   logic [CW-1:0] px_x, px_y;

   always #2 clk = ~clk;

   rle_blit_decoder dut (
      .clk(clk), .rst_n(rst_n), .start(start), .flip_h(flip_h), .flip_v(flip_v),
      .mask_en(mask_en), .x_off(x_off), .y_off(y_off), .clip_w(clip_w), .clip_h(clip_h),
      .in_valid(in_valid), .in_ready(in_ready), .in_byte(in_byte),
      .px_valid(px_valid), .px_ready(px_ready), .px_x(px_x), .px_y(px_y),
      .px_color(px_color), .done(done)
   );

   int checks = 0, errors = 0;
   bit finished = 0;
   logic [7:0] sb [0:1023];
   logic [7:0] rc [0:511];
   int ex_x [0:511], ex_y [0:511], ex_c [0:511];
   int gt_x [0:511], gt_y [0:511], gt_c [0:511];
   int nbytes, ntot, nexp, ngot;

   function automatic string tags(int idx);
      case (idx)
         0: return "R2 R3 R4 R5";
         1: return "R6 R5";
         2: return "R6 R7";
         3: return "R8";
         4: return "R7";
         5: return "R2 R5";
         6: return "R3 R6";
         default: return "R9";
      endcase
   endfunction

   task automatic chk(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic build(int idx);
      int w, h, n, p, k, len, c;
      w = T_W[idx]; h = T_H[idx]; n = w * h;
      sb[0] = 8'(w); sb[1] = 8'(w >> 8); sb[2] = 8'(h); sb[3] = 8'(h >> 8);
      nbytes = 4; p = 0; k = 0;
      if (T_BG[idx] != 0) begin
         sb[4] = 8'h00; sb[5] = 8'd5; nbytes = 6;   // R3: length field 0 = 128
         for (int j = 0; j < 128; j++) rc[j] = 8'd5;
         p = 128;
      end
      while (p < n) begin
         if (k % 2 == 0) begin
            len = 3 + k % 5; if (len > n - p) len = n - p;
            c = (k * 7) % 4;
            sb[nbytes] = 8'(len); sb[nbytes+1] = 8'(c); nbytes += 2;
            for (int j = 0; j < len; j++) begin rc[p] = 8'(c); p++; end
         end else begin
            len = 4; if (len > n - p) len = n - p;
            sb[nbytes] = 8'h80 | 8'(len); nbytes++;
            for (int j = 0; j < len; j++) begin
               c = (k * 13 + j) % 6;
               sb[nbytes] = 8'(c); nbytes++; rc[p] = 8'(c); p++;
            end
         end
         k++;
      end
      sb[nbytes] = 8'hAA; sb[nbytes+1] = 8'h55;   // trailing bytes, R9
      ntot = nbytes + 2;
      nexp = 0;
      for (int i = 0; i < n; i++) begin
         int col, row, mx, my, dx, dy;
         col = i % w; row = i / w;
         mx = (T_FH[idx] != 0) ? w - 1 - col : col;
         my = (T_FV[idx] != 0) ? h - 1 - row : row;
         dx = T_XO[idx] + mx; dy = T_YO[idx] + my;
         if (dx < T_CW[idx] && dy < T_CH[idx] && !(T_MK[idx] != 0 && rc[i] == 8'd0)) begin
            ex_x[nexp] = dx; ex_y[nexp] = dy; ex_c[nexp] = int'(rc[i]); nexp++;
         end
      end
   endtask

   task automatic run_case(int idx);
      int bi, cyc, hx, hy, hc;
      bit held, quiet_bad, xin, xpx, mism;
      build(idx);
      flip_h = T_FH[idx][0]; flip_v = T_FV[idx][0]; mask_en = T_MK[idx][0];
      x_off = CW'(T_XO[idx]); y_off = CW'(T_YO[idx]);
      clip_w = CW'(T_CW[idx]); clip_h = CW'(T_CH[idx]);
      in_valid = 0; px_ready = 0;
      @(posedge clk); #1 start = 1;
      @(posedge clk); #1 start = 0;
      @(negedge clk);
      chk(done == 1'b0, "R1 start clears done", int'(done), 0);
      bi = 0; cyc = 0; ngot = 0; held = 0; quiet_bad = 0;
      in_valid = 1'b1; in_byte = sb[0]; px_ready = 1'b1;
      forever begin
         if (held) chk(px_valid && px_x == CW'(hx) && px_y == CW'(hy) && px_color == 8'(hc),
                       "R10 hold", int'(px_color), hc);
         held = px_valid && !px_ready;
         hx = int'(px_x); hy = int'(px_y); hc = int'(px_color);
         if (done && px_valid) quiet_bad = 1;
         xpx = px_valid && px_ready;
         xin = in_valid && in_ready;
         if (xpx && ngot < 512) begin
            gt_x[ngot] = int'(px_x); gt_y[ngot] = int'(px_y); gt_c[ngot] = int'(px_color);
            ngot++;
         end
         if (!xin && bi >= ntot && done) break;
         if (cyc > 4000) break;
         @(posedge clk); #1;
         cyc++;
         if (xin) bi++;
         in_valid = (bi < ntot) && (cyc % 5 != 3);
         in_byte  = (bi < ntot) ? sb[bi] : 8'h00;
         px_ready = (cyc % 4 != 2);
         @(negedge clk);
      end
      chk(ngot == nexp, {"pixel count ", tags(idx)}, ngot, nexp);
      mism = 0;
      for (int i = 0; i < nexp && i < ngot; i++) begin
         if (!mism && (gt_x[i] != ex_x[i] || gt_y[i] != ex_y[i] || gt_c[i] != ex_c[i])) begin
            mism = 1;
            $display("  case %0d pixel %0d got (%0d,%0d,%0d) exp (%0d,%0d,%0d)", idx, i,
                     gt_x[i], gt_y[i], gt_c[i], ex_x[i], ex_y[i], ex_c[i]);
         end
      end
      chk(!mism, {"pixel values ", tags(idx)}, int'(mism), 0);
      chk(done == 1'b1, "R9 done after image", int'(done), 1);
      chk(bi == ntot && !quiet_bad, "R9 trailing bytes dropped", int'(quiet_bad), 0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1; in_valid = 1; in_byte = 8'h12;
      @(negedge clk);
      chk(px_valid == 1'b0, "R1 reset px_valid", int'(px_valid), 0);
      chk(done == 1'b0, "R1 reset done", int'(done), 0);
      chk(in_ready == 1'b0, "R1 idle in_ready", int'(in_ready), 0);
      for (int c = 0; c < NC; c++) run_case(c);
      // a second start after done must rearm with fresh state
      run_case(0);
      if (!finished) begin
         finished = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++; errors++;
         $display("FAIL watchdog R9 actual=%0d expected=%0d", 0, 1);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule